// File: doc/BRIEF.md
# CCD Sampling Timing Sequencer

This block sequences the control strobes that a correlated-double-sampling image digitizer needs for each pixel. A trigger from the sensor clocking logic starts a pixel. The block then keeps the reference sample-hold in acquisition for a fixed minimum time, and puts it into hold to capture the reference level. After the video settling minimum, it raises a start-convert pulse. The hold is released only when that pulse ends. All of these minimums depend on which of four bandwidth modes is selected. The block converts each minimum from nanoseconds to clock cycles, rounding up, using a clock-period parameter.

The converter delivers each result several conversions after the conversion was started. The block therefore keeps a small queue holding the index of every conversion it has issued. Each returned data-valid strobe takes the oldest index from the queue, so every sample leaves the block tagged with its pixel number. A strobe that arrives with nothing outstanding is flagged, and so is an issue made when the queue is already full. A trigger that arrives before the mode's minimum pixel period has run out is ignored and recorded in a sticky flag. A new mode is picked up only when a pixel is accepted.

Top module: `ccd_strobe_seq`

## Requirements
- R1: While reset is asserted and after it is released, ref_hold_o, start_conv_o, overrun_o, pipe_err_o and smp_valid_o are 0 and bw_sel_o is 2'b00. The first conversion issued after reset carries index 0.
- R2: A trigger is accepted when it is sampled with the sequencer idle and the minimum period elapsed. After an accepted trigger, ref_hold_o stays 0 for ceil(T_acq/CLK_PERIOD_NS) cycles and then goes to 1. T_acq is 100, 200, 450 or 600 ns for the mode values 0, 1, 2 and 3 of mode_i. Bit 0 of mode_i is the first select bit and bit 1 is the second.
- R3: ref_hold_o stays 1 for ceil(T_set/CLK_PERIOD_NS) cycles before start_conv_o rises. T_set is 120, 250, 500 or 1000 ns for modes 0 to 3.
- R4: start_conv_o is high for ceil(PW_NS/CLK_PERIOD_NS) cycles (PW_NS defaults to 20, which is inside the allowed 20 to 150 ns). ref_hold_o stays 1 for the whole pulse and falls in the same cycle as start_conv_o.
- R5: The minimum pixel period is ceil(T_per/CLK_PERIOD_NS) cycles, with T_per equal to 333, 500, 1000 or 2000 ns for modes 0 to 3. A trigger sampled exactly that many cycles after the previous accepted trigger is accepted, and overrun_o stays 0.
- R6: A trigger sampled earlier than the period in R5 starts no sequence. ref_hold_o and start_conv_o stay 0. overrun_o goes to 1 on the next cycle and stays 1 until reset.
- R7: bw_sel_o takes the value of mode_i when a trigger is accepted. It does not change while a sequence is in progress, even if mode_i changes.
- R8: Each start-convert pulse issues the next pixel index, counting up from 0 and wrapping at 2^IDX_W.
- R9: When dv_i is sampled high with at least one conversion outstanding, smp_valid_o is 1 on the next cycle. At the same time smp_data_o and smp_oor_o show the data_i and oor_i that were sampled, and smp_idx_o shows the oldest outstanding index, which is then retired.
- R10: pipe_err_o goes to 1 and stays 1 until reset in two cases. The first is dv_i sampled high with nothing outstanding, and then smp_valid_o stays 0. The second is a conversion issued while PIPE_DEPTH indices are already outstanding with no retirement in the same cycle, and then the new index is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_start_i | input | 1 | Pixel-start trigger from sensor clocking |
| mode_i | input | 2 | Requested bandwidth mode |
| dv_i | input | 1 | Data-valid strobe returned by the converter |
| data_i | input | DATA_W | Returned conversion result |
| oor_i | input | 1 | Returned out-of-range flag |
| ref_hold_o | output | 1 | Reference sample-hold control, 1 = hold |
| start_conv_o | output | 1 | Start-convert pulse |
| bw_sel_o | output | 2 | Bandwidth select code driven to the front end |
| overrun_o | output | 1 | Sticky early-trigger flag |
| smp_valid_o | output | 1 | Tagged sample valid |
| smp_data_o | output | DATA_W | Tagged sample data |
| smp_oor_o | output | 1 | Tagged sample out-of-range flag |
| smp_idx_o | output | IDX_W | Pixel index of the tagged sample |
| pipe_err_o | output | 1 | Sticky return-pipeline error |

## Verification
The bench drives each of the four modes and measures the three phase lengths to the cycle. A design that rounds down, that indexes the wrong timing table, or that counts one cycle too many or too few shows up as a wrong length. For each mode it also triggers one cycle before the minimum period and then exactly at it. A design whose period is off by one either accepts the early trigger or flags the legal one. A design that picks up a mode change in the middle of a sequence changes bw_sel_o while ref_hold_o is still high. On the return side the bench checks:
- that indices come back in issue order across a partly drained queue;
- that a data-valid strobe with nothing outstanding raises the error flag and produces no sample;
- that an issue made while the queue is full drops the newest index and keeps the oldest.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_HOLD, ST_CONV} seq_st_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // mode value: bit0 = first select bit, bit1 = second
  function automatic int unsigned acq_ns(input int unsigned m);
    case (m)
      0: return 100;
      1: return 200;
      2: return 450;
      default: return 600;
    endcase
  endfunction

  function automatic int unsigned set_ns(input int unsigned m);
    case (m)
      0: return 120;
      1: return 250;
      2: return 500;
      default: return 1000;
    endcase
  endfunction

  function automatic int unsigned per_ns(input int unsigned m);
    case (m)
      0: return 333;
      1: return 500;
      2: return 1000;
      default: return 2000;
    endcase
  endfunction

endpackage

// File: rtl/ccdseq_fsm.sv
module ccdseq_fsm
  import ccdseq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned PW_NS         = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pix_start_i,
  input  logic [1:0] mode_i,
  output logic       ref_hold_o,
  output logic       start_conv_o,
  output logic [1:0] bw_sel_o,
  output logic       overrun_o,
  output logic       issue_o
);

  localparam int unsigned PER_MAX = ns2cyc(per_ns(3), CLK_PERIOD_NS);
  localparam int unsigned PW_CYC  = ns2cyc(PW_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_W   = $clog2(((PER_MAX > PW_CYC) ? PER_MAX : PW_CYC) + 1);

  logic [CNT_W-1:0] acq_tab [4];
  logic [CNT_W-1:0] set_tab [4];
  logic [CNT_W-1:0] per_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_tab
    assign acq_tab[g] = CNT_W'(ns2cyc(acq_ns(g), CLK_PERIOD_NS));
    assign set_tab[g] = CNT_W'(ns2cyc(set_ns(g), CLK_PERIOD_NS));
    assign per_tab[g] = CNT_W'(ns2cyc(per_ns(g), CLK_PERIOD_NS));
  end

  seq_st_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_q;
  logic [1:0]       bw_q;
  logic             ovr_q;
  logic             accept;

  assign accept = pix_start_i && (state_q == ST_IDLE) && (per_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      per_q   <= '0;
      bw_q    <= 2'b00;
      ovr_q   <= 1'b0;
    end else begin
      if (per_q != '0) per_q <= per_q - 1'b1;
      if (pix_start_i && !accept) ovr_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ACQ;
          cnt_q   <= acq_tab[mode_i] - 1'b1;
          per_q   <= per_tab[mode_i] - 1'b1;
          bw_q    <= mode_i;
        end
        ST_ACQ: if (cnt_q == '0) begin
          state_q <= ST_HOLD;
          cnt_q   <= set_tab[bw_q] - 1'b1;
        end else cnt_q <= cnt_q - 1'b1;
        ST_HOLD: if (cnt_q == '0) begin
          state_q <= ST_CONV;
          cnt_q   <= CNT_W'(PW_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        default: if (cnt_q == '0) state_q <= ST_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  assign ref_hold_o   = (state_q == ST_HOLD) || (state_q == ST_CONV);
  assign start_conv_o = (state_q == ST_CONV);
  assign bw_sel_o     = bw_q;
  assign overrun_o    = ovr_q;
  assign issue_o      = (state_q == ST_HOLD) && (cnt_q == '0);

  AST_HOLD_REL_AFTER_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_hold_o) |-> $past(start_conv_o)); // R4
  AST_BW_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) != ST_IDLE) |-> $stable(bw_sel_o)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(overrun_o) |-> overrun_o); // R6
  AST_NO_EARLY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_start_i && per_q != '0) |=> (state_q != ST_ACQ) || $past(state_q == ST_ACQ)); // R6

endmodule

// File: rtl/ccdseq_tag_fifo.sv
module ccdseq_tag_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);

  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= push_data_i;
        wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R10
  AST_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o); // R10

endmodule

// File: rtl/ccd_strobe_seq.sv
module ccd_strobe_seq #(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned PW_NS         = 20,
  parameter int unsigned PIPE_DEPTH    = 4,
  parameter int unsigned DATA_W        = 14,
  parameter int unsigned IDX_W         = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_start_i,
  input  logic [1:0]        mode_i,
  input  logic              dv_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              oor_i,
  output logic              ref_hold_o,
  output logic              start_conv_o,
  output logic [1:0]        bw_sel_o,
  output logic              overrun_o,
  output logic              smp_valid_o,
  output logic [DATA_W-1:0] smp_data_o,
  output logic              smp_oor_o,
  output logic [IDX_W-1:0]  smp_idx_o,
  output logic              pipe_err_o
);

  logic             issue;
  logic [IDX_W-1:0] pix_idx_q;
  logic [IDX_W-1:0] head;
  logic             empty, full;
  logic             err_q, val_q, oor_q;
  logic [DATA_W-1:0] data_q;
  logic [IDX_W-1:0]  idx_q;

  ccdseq_fsm #(.CLK_PERIOD_NS(CLK_PERIOD_NS), .PW_NS(PW_NS)) u_fsm (
    .clk_i, .rst_ni, .pix_start_i, .mode_i,
    .ref_hold_o, .start_conv_o, .bw_sel_o, .overrun_o,
    .issue_o(issue)
  );

  ccdseq_tag_fifo #(.DEPTH(PIPE_DEPTH), .W(IDX_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(issue), .push_data_i(pix_idx_q),
    .pop_i(dv_i), .head_o(head), .empty_o(empty), .full_o(full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_idx_q <= '0;
      err_q     <= 1'b0;
      val_q     <= 1'b0;
      oor_q     <= 1'b0;
      data_q    <= '0;
      idx_q     <= '0;
    end else begin
      if (issue) pix_idx_q <= pix_idx_q + 1'b1;
      if ((dv_i && empty) || (issue && full && !dv_i)) err_q <= 1'b1;
      val_q <= dv_i && !empty;
      if (dv_i && !empty) begin
        data_q <= data_i;
        oor_q  <= oor_i;
        idx_q  <= head;
      end
    end
  end

  assign pipe_err_o  = err_q;
  assign smp_valid_o = val_q;
  assign smp_data_o  = data_q;
  assign smp_oor_o   = oor_q;
  assign smp_idx_o   = idx_q;

  AST_DV_EMPTY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dv_i && empty) |=> (pipe_err_o && !smp_valid_o)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pipe_err_o) |-> pipe_err_o); // R10
  AST_VALID_FROM_DV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> $past(dv_i)); // R9

endmodule

// File: tb/sim_ccd_strobe_seq.sv
module sim_ccd_strobe_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        dv = 1'b0;
  logic [13:0] data = '0;
  logic        oor = 1'b0;
  logic        ref_hold, start_conv, overrun, smp_valid, smp_oor, pipe_err;
  logic [1:0]  bw_sel;
  logic [13:0] smp_data;
  logic [7:0]  smp_idx;

  int tests = 0;
  int fails = 0;
  int el = 0;

  always #2 clk = ~clk;

  ccd_strobe_seq #(.CLK_PERIOD_NS(4), .PW_NS(20), .PIPE_DEPTH(4), .DATA_W(14), .IDX_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pix_start_i(pix_start), .mode_i(mode),
    .dv_i(dv), .data_i(data), .oor_i(oor),
    .ref_hold_o(ref_hold), .start_conv_o(start_conv), .bw_sel_o(bw_sel),
    .overrun_o(overrun), .smp_valid_o(smp_valid), .smp_data_o(smp_data),
    .smp_oor_o(smp_oor), .smp_idx_o(smp_idx), .pipe_err_o(pipe_err)
  );

  // mode, acquisition cycles, settling cycles, period cycles at 4 ns
  localparam int VEC [4][4] = '{
    '{0, 25,  30,  84},
    '{1, 50,  63, 125},
    '{2, 113, 125, 250},
    '{3, 150, 250, 500}
  };
  localparam int PW_C = 5;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    el++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic trig();
    pix_start = 1'b1;
    @(negedge clk);
    pix_start = 1'b0;
    el = 1;
  endtask

  task automatic measure(output int a, output int s, output int w);
    a = 0; s = 0; w = 0;
    while (!ref_hold && a < 3000) begin a++; tick(); end
    while (ref_hold && !start_conv && s < 3000) begin s++; tick(); end
    while (start_conv && w < 3000) begin w++; tick(); end
  endtask

  task automatic fire(input int per);
    trig();
    while (el < per) tick();
  endtask

  task automatic ret(input logic [13:0] d, input logic o);
    dv = 1'b1; data = d; oor = o;
    @(negedge clk);
    dv = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int a, s, w;
    @(negedge clk);
    // R1 during reset
    chk("R1 ref_hold in reset", int'(ref_hold), 0);
    chk("R1 start_conv in reset", int'(start_conv), 0);
    do_reset();
    chk("R1 bw_sel", int'(bw_sel), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 pipe_err", int'(pipe_err), 0);
    chk("R1 smp_valid", int'(smp_valid), 0);

    for (int v = 0; v < 4; v++) begin
      do_reset();
      mode = 2'(VEC[v][0]);
      trig();
      mode = ~2'(VEC[v][0]);
      measure(a, s, w);
      chk($sformatf("R2 acq mode %0d", v), a, VEC[v][1]);
      chk($sformatf("R3 settle mode %0d", v), s, VEC[v][2]);
      chk($sformatf("R4 pulse width mode %0d", v), w, PW_C);
      chk($sformatf("R4 hold released with pulse mode %0d", v), int'(ref_hold), 0);
      chk($sformatf("R7 bw_sel kept mode %0d", v), int'(bw_sel), VEC[v][0]);
      mode = 2'(VEC[v][0]);
      while (el < VEC[v][3]) tick();
      trig();
      chk($sformatf("R5 legal trigger no overrun mode %0d", v), int'(overrun), 0);
      measure(a, s, w);
      chk($sformatf("R5 second pixel acq mode %0d", v), a, VEC[v][1]);
      while (el < VEC[v][3] - 1) tick();
      trig();
      chk($sformatf("R6 overrun set mode %0d", v), int'(overrun), 1);
      a = 0;
      for (int k = 0; k < VEC[v][1] + 3; k++) begin
        if (ref_hold || start_conv) a++;
        tick();
      end
      chk($sformatf("R6 early trigger ignored mode %0d", v), a, 0);
      chk($sformatf("R6 overrun sticky mode %0d", v), int'(overrun), 1);
    end

    // return path tagging
    do_reset();
    mode = 2'b00;
    for (int k = 0; k < 4; k++) fire(84);
    ret(14'h1234, 1'b0);
    chk("R9 valid", int'(smp_valid), 1);
    chk("R8 first index", int'(smp_idx), 0);
    chk("R9 data", int'(smp_data), 'h1234);
    chk("R9 oor clear", int'(smp_oor), 0);
    ret(14'h3FFF, 1'b1);
    chk("R9 second index", int'(smp_idx), 1);
    chk("R9 oor set", int'(smp_oor), 1);
    @(negedge clk);
    chk("R9 valid one cycle", int'(smp_valid), 0);
    for (int k = 0; k < 2; k++) fire(84);
    for (int k = 2; k < 6; k++) begin
      ret(14'(k * 3), 1'b0);
      chk("R8 in-order index", int'(smp_idx), k);
      chk("R9 data follows", int'(smp_data), k * 3);
    end
    chk("R10 no error yet", int'(pipe_err), 0);
    ret(14'h0055, 1'b0);
    chk("R10 dv on empty valid", int'(smp_valid), 0);
    chk("R10 dv on empty error", int'(pipe_err), 1);

    do_reset();
    for (int k = 0; k < 4; k++) fire(84);
    chk("R10 full without error", int'(pipe_err), 0);
    fire(84);
    chk("R10 overflow error", int'(pipe_err), 1);
    ret(14'h0001, 1'b0);
    chk("R10 oldest kept", int'(smp_idx), 0);
    for (int k = 1; k < 4; k++) ret(14'h0001, 1'b0);
    chk("R10 newest dropped", int'(smp_idx), 3);
    ret(14'h0002, 1'b0);
    chk("R10 drained", int'(smp_valid), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule